// File: doc/BRIEF.md
# Queue and Statistics Interrupt Status Bank

This block collects error and wrap events from an eight-queue packet controller and keeps them as sticky flags that software can read. Each queue sends an overflow pulse and an underrun pulse. Up to thirty-two transmit statistics counters each send a pulse when they wrap. Every pulse sets a status flag. The flag stays set until software reads the word that holds it, and that read clears the whole word.

A thirty-two bit mask register selects which queue flags drive the queue interrupt level, `q_irq_o`. Flags whose mask bit is clear still set on their event and still clear on a read. They simply do not reach the interrupt output. The counter wrap flags have no mask, and any of them drives `roll_irq_o`. Both outputs go to a higher-level interrupt collector, which is outside this block.

Software reaches the three words through a single-cycle request port. The request carries an address and a write flag. Read data is registered.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, the queue status word, the mask word and the wrap status word all read 0, and both `q_irq_o` and `roll_irq_o` are low.
- R2: The queue status word is at offset 0x1C8. For queue n, an overflow pulse sets bit 4n+3 and an underrun pulse sets bit 4n+2. Bits 4n+1 and 4n always read 0.
- R3: The wrap status word is at offset 0x1D0. A pulse on `roll_i[i]` sets bit i.
- R4: A status flag that has been set stays set until its word is read, however many cycles pass.
- R5: A read of a status word returns the current value and then clears every flag in that word. If no new event arrives, the next read returns 0.
- R6: If an event arrives in the same cycle as a read of its word, the read returns the old value and the flag for that event remains set.
- R7: The mask word is at offset 0x1CC. It is a 32-bit read/write register, and a read returns the last value written.
- R8: `q_irq_o` is high exactly when a queue status bit is set and its mask bit is 1. A bit whose mask bit is 0 still sets and still clears on a read.
- R9: `roll_irq_o` is high exactly when any wrap status bit is set.
- R10: Writes to 0x1C8 or 0x1D0 change no status flag.
- R11: A read from any offset other than the three mapped ones returns 0 and clears nothing.
- R12: `rdata_o` carries the result of a read from the clock edge that accepts the request. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| q_ovf_i | input | NUM_QUEUES | Per-queue overflow pulses |
| q_udr_i | input | NUM_QUEUES | Per-queue underrun pulses |
| roll_i | input | NUM_CNT | Per-counter wrap pulses |
| q_irq_o | output | 1 | Level: a masked-in queue flag is set |
| roll_irq_o | output | 1 | Level: a counter wrap flag is set |

## Verification
An event pulse that the edge at cycle t samples is visible on the interrupt levels just after that edge, because those levels are decoded straight from the flag registers. Read data is due one edge after the request. The clear it causes shows on the levels after that same edge. The bench changes inputs on the falling edge and samples outputs on the next falling edge. Each check therefore falls half a cycle after the single register stage that produces the result. The same-cycle collision case drives the event and the read on one falling edge, so that both are sampled by one rising edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned Q_FIELD_W   = 4;
  localparam int unsigned Q_OVF_BIT   = 3;
  localparam int unsigned Q_UDR_BIT   = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_QSTAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_ROLL = 2'd3
  } reg_sel_e;

  function automatic int unsigned q_ovf_pos(input int unsigned n);
    return Q_FIELD_W * n + Q_OVF_BIT;
  endfunction

  function automatic int unsigned q_udr_pos(input int unsigned n);
    return Q_FIELD_W * n + Q_UDR_BIT;
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] QSTAT_OFF = 12'h1C8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 12'h1CC,
  parameter logic [ADDR_W-1:0] ROLL_OFF  = 12'h1D0
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              rd_qstat_o,
  output logic              rd_roll_o,
  output logic              rd_any_o,
  output logic              wr_mask_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == QSTAT_OFF)     sel_o = SEL_QSTAT;
    else if (addr_i == MASK_OFF) sel_o = SEL_MASK;
    else if (addr_i == ROLL_OFF) sel_o = SEL_ROLL;
  end

  assign rd_any_o   = req_i && !we_i;
  assign rd_qstat_o = rd_any_o && (sel_o == SEL_QSTAT);
  assign rd_roll_o  = rd_any_o && (sel_o == SEL_ROLL);
  // status offsets are read-only: only the mask accepts writes
  assign wr_mask_o  = req_i && we_i && (sel_o == SEL_MASK);
endmodule

// File: rtl/irq_queue_pack.sv
module irq_queue_pack
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 8
) (
  input  logic [NUM_QUEUES-1:0] q_ovf_i,
  input  logic [NUM_QUEUES-1:0] q_udr_i,
  output logic [DATA_W-1:0]     set_o
);
  localparam int unsigned USED_W = Q_FIELD_W * NUM_QUEUES;

  initial begin
    if (USED_W > DATA_W) $error("irq_queue_pack: too many queues for one word");
  end

  always_comb begin
    set_o = '0;
    for (int unsigned n = 0; n < NUM_QUEUES; n++) begin
      set_o[q_ovf_pos(n)] = q_ovf_i[n];
      set_o[q_udr_pos(n)] = q_udr_i[n];
    end
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  // set wins over clear so a colliding event survives the read
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i)    flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 8,
  parameter int unsigned NUM_CNT    = 32,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] QSTAT_OFF = 12'h1C8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 12'h1CC,
  parameter logic [ADDR_W-1:0] ROLL_OFF  = 12'h1D0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_QUEUES-1:0] q_ovf_i,
  input  logic [NUM_QUEUES-1:0] q_udr_i,
  input  logic [NUM_CNT-1:0]    roll_i,
  output logic                  q_irq_o,
  output logic                  roll_irq_o
);
  localparam int unsigned ROLL_PAD = DATA_W - NUM_CNT;

  reg_sel_e          sel;
  logic              rd_qstat, rd_roll, rd_any, wr_mask;
  logic [DATA_W-1:0] q_set, q_stat, roll_stat;
  logic [DATA_W-1:0] roll_set;
  logic [DATA_W-1:0] mask_q, rdata_q, rd_mux;

  irq_reg_decode #(
    .ADDR_W   (ADDR_W),
    .QSTAT_OFF(QSTAT_OFF),
    .MASK_OFF (MASK_OFF),
    .ROLL_OFF (ROLL_OFF)
  ) u_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .sel_o     (sel),
    .rd_qstat_o(rd_qstat),
    .rd_roll_o (rd_roll),
    .rd_any_o  (rd_any),
    .wr_mask_o (wr_mask)
  );

  irq_queue_pack #(.NUM_QUEUES(NUM_QUEUES)) u_qpack (
    .q_ovf_i(q_ovf_i),
    .q_udr_i(q_udr_i),
    .set_o  (q_set)
  );

  irq_sticky_bank #(.WIDTH(DATA_W)) u_qstat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (q_set),
    .clr_i (rd_qstat),
    .flag_o(q_stat)
  );

  if (ROLL_PAD > 0) begin : g_roll_pad
    assign roll_set = {{ROLL_PAD{1'b0}}, roll_i};
  end else begin : g_roll_full
    assign roll_set = roll_i;
  end

  irq_sticky_bank #(.WIDTH(DATA_W)) u_roll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (roll_set),
    .clr_i (rd_roll),
    .flag_o(roll_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i;
  end

  always_comb begin
    unique case (sel)
      SEL_QSTAT: rd_mux = q_stat;
      SEL_MASK:  rd_mux = mask_q;
      SEL_ROLL:  rd_mux = roll_stat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign q_irq_o    = |(q_stat & mask_q);
  assign roll_irq_o = |roll_stat;
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int unsigned NUM_QUEUES = 8,
  parameter int unsigned NUM_CNT    = 32,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] QSTAT_OFF = 12'h1C8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 12'h1CC,
  parameter logic [ADDR_W-1:0] ROLL_OFF  = 12'h1D0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_QUEUES-1:0] q_ovf_i,
  input logic [NUM_QUEUES-1:0] q_udr_i,
  input logic [NUM_CNT-1:0]    roll_i,
  input logic [31:0]           mask_q,
  input logic                  q_irq_o,
  input logic                  roll_irq_o
);
  logic rd_req, unmapped;
  assign rd_req   = req_i && !we_i;
  assign unmapped = (addr_i != QSTAT_OFF) && (addr_i != MASK_OFF) && (addr_i != ROLL_OFF);

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && addr_i == QSTAT_OFF |=> (rdata_o & 32'h3333_3333) == 32'h0);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && unmapped |=> rdata_o == 32'h0);

  // R6
  roll_event_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_i != '0 |=> roll_irq_o);

  // R5
  roll_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && addr_i == ROLL_OFF && roll_i == '0 |=> !roll_irq_o);

  // R4
  roll_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_irq_o && !(rd_req && addr_i == ROLL_OFF) |=> roll_irq_o);

  // R10
  roll_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == ROLL_OFF && roll_i == '0 && !roll_irq_o |=> !roll_irq_o);

  // R8
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == 32'h0 |-> !q_irq_o);

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));

  // R8
  q_event_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_ovf_i[0] && mask_q[3]) |=> q_irq_o);

  logic unused_ok;
  assign unused_ok = ^{q_udr_i};
endmodule

bind irq_status_bank irq_status_bank_chk #(
  .NUM_QUEUES(NUM_QUEUES),
  .NUM_CNT   (NUM_CNT),
  .ADDR_W    (ADDR_W),
  .QSTAT_OFF (QSTAT_OFF),
  .MASK_OFF  (MASK_OFF),
  .ROLL_OFF  (ROLL_OFF)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .q_ovf_i   (q_ovf_i),
  .q_udr_i   (q_udr_i),
  .roll_i    (roll_i),
  .mask_q    (mask_q),
  .q_irq_o   (q_irq_o),
  .roll_irq_o(roll_irq_o)
);

// File: tb/irq_status_bank_bench.sv
module irq_status_bank_bench;
  localparam int NQ = 8;
  localparam int NC = 32;
  localparam logic [11:0] A_Q = 12'h1C8, A_M = 12'h1CC, A_R = 12'h1D0;

  typedef struct packed {
    logic [31:0] mask;
    logic [7:0]  ovf;
    logic [7:0]  udr;
    logic [31:0] word;
    logic        irq;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 8'h01, 8'h00, 32'h0000_0008, 1'b0},
    '{32'h0000_0008, 8'h01, 8'h00, 32'h0000_0008, 1'b1},
    '{32'h4000_0000, 8'h00, 8'h80, 32'h4000_0000, 1'b1},
    '{32'h3333_3333, 8'hFF, 8'hFF, 32'hCCCC_CCCC, 1'b0},
    '{32'h0000_0040, 8'h55, 8'hAA, 32'h4848_4848, 1'b1},
    '{32'h8000_0000, 8'h0F, 8'hF0, 32'h4444_8888, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NQ-1:0] ovf = '0, udr = '0;
  logic [NC-1:0] roll = '0;
  logic q_irq, roll_irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_status_bank u_irq_status_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .q_ovf_i(ovf), .q_udr_i(udr),
    .roll_i(roll), .q_irq_o(q_irq), .roll_irq_o(roll_irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; v = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic pulse(input logic [NQ-1:0] o, input logic [NQ-1:0] u, input logic [NC-1:0] r);
    @(negedge clk); ovf = o; udr = u; roll = r;
    @(negedge clk); ovf = '0; udr = '0; roll = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 q_irq", {31'b0, q_irq}, 32'h0);
    chk("R1 roll_irq", {31'b0, roll_irq}, 32'h0);
    rd(A_Q, v); chk("R1 qstat", v, 32'h0);
    rd(A_M, v); chk("R1 mask", v, 32'h0);
    rd(A_R, v); chk("R1 roll", v, 32'h0);

    // R2 R5 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(A_M, VECS[i].mask);
      pulse(VECS[i].ovf, VECS[i].udr, '0);
      chk("R8 irq after event", {31'b0, q_irq}, {31'b0, VECS[i].irq});
      rd(A_Q, v); chk("R2 qstat word", v, VECS[i].word);
      chk("R5 irq after clear", {31'b0, q_irq}, 32'h0);
      rd(A_Q, v); chk("R5 reread zero", v, 32'h0);
    end

    // R7 mask readback
    wr(A_M, 32'hDEAD_BEEF); rd(A_M, v); chk("R7 mask", v, 32'hDEAD_BEEF);
    wr(A_M, 32'h0000_0008);

    // R3 R9 rollover
    pulse('0, '0, 32'h8000_0001);
    chk("R9 roll_irq set", {31'b0, roll_irq}, 32'h1);
    // R4 sticky across idle cycles
    repeat (20) @(negedge clk);
    chk("R4 roll_irq held", {31'b0, roll_irq}, 32'h1);
    rd(A_R, v); chk("R3 roll word", v, 32'h8000_0001);
    chk("R9 roll_irq cleared", {31'b0, roll_irq}, 32'h0);

    // R10 writes to status offsets ignored
    pulse(8'h02, 8'h00, 32'h0000_0100);
    wr(A_Q, 32'hFFFF_FFFF); wr(A_R, 32'h0000_0000);
    rd(A_Q, v); chk("R10 qstat after write", v, 32'h0000_0080);
    rd(A_R, v); chk("R10 roll after write", v, 32'h0000_0100);
    wr(A_R, 32'hFFFF_FFFF);
    chk("R10 roll_irq after write", {31'b0, roll_irq}, 32'h0);

    // R11 unmapped read, no side effect
    pulse(8'h00, 8'h02, '0);
    rd(12'h100, v); chk("R11 unmapped data", v, 32'h0);
    rd(12'h1C4, v); chk("R11 unmapped data 2", v, 32'h0);
    rd(A_Q, v); chk("R11 qstat kept", v, 32'h0000_0040);

    // R6 collision: event in same cycle as read
    pulse(8'h01, 8'h00, '0);
    @(negedge clk); req = 1; we = 0; addr = A_Q; ovf = 8'h01;
    @(negedge clk); req = 0; ovf = '0; v = rdata;
    chk("R6 old value returned", v, 32'h0000_0008);
    chk("R6 irq stays", {31'b0, q_irq}, 32'h1);
    rd(A_Q, v); chk("R6 bit kept", v, 32'h0000_0008);
    @(negedge clk); req = 1; we = 0; addr = A_R; roll = 32'h0000_0004;
    @(negedge clk); req = 0; roll = '0; v = rdata;
    chk("R6 roll old value", v, 32'h0);
    rd(A_R, v); chk("R6 roll bit kept", v, 32'h0000_0004);

    // R12 rdata holds between reads
    repeat (3) @(negedge clk);
    chk("R12 rdata held", rdata, 32'h0000_0004);
    wr(A_M, 32'h1234_5678);
    chk("R12 rdata held over write", rdata, 32'h0000_0004);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule